// File: doc/BRIEF.md
# Bus cycle break condition matcher

This debug block watches the stream of completed bus cycles on a processor bus. For each cycle it compares four attributes against fields in an 8-bit implemented control register. The attributes are the issuing master (CPU or DMA engine), the cycle kind (instruction fetch or data access), the direction and the operand size. When every enabled field agrees with the cycle, the block raises a break request for one clock.

Software programs the 16-bit control word through a simple write strobe and reads it back on a parallel read bus. The bus-cycle observation port carries a valid strobe and the cycle attributes. Each two-bit select field has a code that leaves its attribute out of the comparison. If the register holds all zeros, the break is disabled entirely.

Top module: `bus_break_matcher`

## Requirements
- R1: While rst_ni is low, and directly after it rises, the control word reads 0x0000 and brk_o is low.
- R2: Bits 15:8 of the control word always read as zero, and writing ones to them has no effect.
- R3: Bits 7:6 select the master. 00 means the master is not compared. 01 or 11 matches CPU cycles (cyc_dma_i=0). 10 matches DMA cycles (cyc_dma_i=1).
- R4: Bits 5:4 select the cycle kind. 00 means not compared. 01 matches instruction fetch (cyc_data_i=0). 10 matches data access (cyc_data_i=1). 11 matches either kind.
- R5: Bits 3:2 select the direction. 00 means not compared. 01 matches reads (cyc_write_i=0). 10 matches writes (cyc_write_i=1). 11 matches either direction.
- R6: Bits 1:0 select the size. 00 means not compared. 01 matches byte, 10 matches word and 11 matches longword. These correspond to cyc_size_i values 00, 01 and 10; a cyc_size_i of 11 matches no enabled size field.
- R7: A field set to 00 counts as matching when at least one other field is non-zero. When bits 7:0 are all zero, no break is ever raised.
- R8: brk_o is a registered pulse. It is high for exactly the one clock after a valid cycle that matches, and it stays low after any clock in which cyc_valid_i was low.
- R9: A write updates the control word at the clock edge that ends the write. A bus cycle presented in the same clock as the write is judged against the old value, and the following cycle is judged against the new value.
- R10: Bits 7:0 read back exactly as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read data |
| cyc_valid_i | input | 1 | A bus cycle completes this clock |
| cyc_dma_i | input | 1 | Master: 1 DMA, 0 CPU |
| cyc_data_i | input | 1 | Kind: 1 data access, 0 instruction fetch |
| cyc_write_i | input | 1 | Direction: 1 write, 0 read |
| cyc_size_i | input | 2 | Size: 00 byte, 01 word, 10 longword |
| brk_o | output | 1 | Break request pulse |

## Verification
A register write and an observed bus cycle can occur in the same clock. That bus cycle must be judged against the old setting. The bench creates this case by holding a CPU-only setting and then, in one clock, writing a DMA-only setting while presenting a CPU cycle. It expects brk_o to be high on the next clock. A second CPU cycle, presented after the write has landed, must then give brk_o low. All 256 settings of the implemented bits are also swept against all 32 cycle attribute combinations. The expected result is computed field by field from the encodings.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned IMPL_W = 8;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_SEL  = IMPL_W / SEL_W;

  // field index, lsb position = index*SEL_W
  localparam int unsigned F_SIZE   = 0;
  localparam int unsigned F_DIR    = 1;
  localparam int unsigned F_KIND   = 2;
  localparam int unsigned F_MASTER = 3;

  typedef enum logic [1:0] {
    SEL_PAIR   = 2'd0,  // 01 attr=0, 10 attr=1, 11 either
    SEL_MASTER = 2'd1,  // x1 attr=0, 10 attr=1
    SEL_CODE   = 2'd2   // nonzero sel matches attr == sel-1
  } sel_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    logic       dma;
    logic       data;
    logic       write;
    logic [1:0] size;
  } bus_cyc_t;
endpackage

// File: rtl/bbm_cfg_reg.sv
module bbm_cfg_reg #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned IMPL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [IMPL_W-1:0] cfg_o
);
  localparam int unsigned PAD_W = REG_W - IMPL_W;

  logic [IMPL_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i[IMPL_W-1:0];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata_o = {{PAD_W{1'b0}}, cfg_q};
    end else begin : g_nopad
      assign rdata_o = cfg_q;
    end
  endgenerate

  assign cfg_o = cfg_q;
endmodule

// File: rtl/bbm_sel_match.sv
module bbm_sel_match
  import bbm_pkg::*;
#(
  parameter sel_mode_e MODE = SEL_PAIR
) (
  input  logic [1:0] sel_i,
  input  logic [1:0] attr_i,
  output logic       en_o,
  output logic       hit_o
);
  assign en_o = |sel_i;

  generate
    if (MODE == SEL_MASTER) begin : g_master
      always_comb begin
        if (sel_i[0])       hit_o = ~attr_i[0];
        else if (sel_i[1])  hit_o = attr_i[0];
        else                hit_o = 1'b1;
      end
    end else if (MODE == SEL_CODE) begin : g_code
      always_comb begin
        if (sel_i == 2'b00) hit_o = 1'b1;
        else                hit_o = (attr_i == (sel_i - 2'd1));
      end
    end else begin : g_pair
      always_comb begin
        if (sel_i == 2'b00) hit_o = 1'b1;
        else                hit_o = (sel_i[0] & ~attr_i[0]) | (sel_i[1] & attr_i[0]);
      end
    end
  endgenerate
endmodule

// File: rtl/bbm_match_core.sv
module bbm_match_core
  import bbm_pkg::*;
#(
  parameter int unsigned N = N_SEL
) (
  input  logic [2*N-1:0] cfg_i,
  input  bus_cyc_t       cyc_i,
  output logic           match_o
);
  logic [N-1:0] en;
  logic [N-1:0] hit;
  logic [1:0]   attr [N];

  always_comb begin
    for (int i = 0; i < N; i++) attr[i] = 2'b00;
    attr[F_SIZE]   = cyc_i.size;
    attr[F_DIR]    = {1'b0, cyc_i.write};
    attr[F_KIND]   = {1'b0, cyc_i.data};
    attr[F_MASTER] = {1'b0, cyc_i.dma};
  end

  for (genvar g = 0; g < N; g++) begin : g_sel
    localparam sel_mode_e M = (g == F_MASTER) ? SEL_MASTER :
                              (g == F_SIZE)   ? SEL_CODE   : SEL_PAIR;
    bbm_sel_match #(.MODE(M)) u_sel (
      .sel_i  (cfg_i[2*g +: 2]),
      .attr_i (attr[g]),
      .en_o   (en[g]),
      .hit_o  (hit[g])
    );
  end

  // any field enabled and every field agrees
  assign match_o = (|en) & (&hit);
endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
  import bbm_pkg::*;
#(
  parameter int unsigned REG_W  = bbm_pkg::REG_W,
  parameter int unsigned IMPL_W = bbm_pkg::IMPL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             cyc_valid_i,
  input  logic             cyc_dma_i,
  input  logic             cyc_data_i,
  input  logic             cyc_write_i,
  input  logic [1:0]       cyc_size_i,
  output logic             brk_o
);
  localparam int unsigned N = IMPL_W / 2;

  logic [IMPL_W-1:0] cfg;
  bus_cyc_t          cyc;
  logic              match;
  logic              brk_q;

  bbm_cfg_reg #(.REG_W(REG_W), .IMPL_W(IMPL_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  assign cyc = '{dma: cyc_dma_i, data: cyc_data_i, write: cyc_write_i, size: cyc_size_i};

  // compares against the pre-write value: the write lands at the same edge
  bbm_match_core #(.N(N)) u_core (
    .cfg_i   (cfg),
    .cyc_i   (cyc),
    .match_o (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_q <= 1'b0;
    else         brk_q <= cyc_valid_i & match;
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
  parameter int unsigned REG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             cyc_valid_i,
  input logic             brk_o
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (reg_rdata_o == '0 && !brk_o);
    end
  end

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:8] == '0);

  a_r10_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[7:0] == $past(reg_wdata_i[7:0]));

  a_r7_all_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[7:0] == 8'h00) |=> !brk_o);

  a_r8_no_valid_no_brk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |=> !brk_o);

  a_r9_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(reg_rdata_o));
endmodule

bind bus_break_matcher bbm_checker #(.REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .cyc_valid_i (cyc_valid_i),
  .brk_o       (brk_o)
);

// File: tb/bus_break_matcher_bench.sv
`timescale 1ns/1ps
module bus_break_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        valid = 1'b0;
  logic        dma = 1'b0, data = 1'b0, wr = 1'b0;
  logic [1:0]  sz = 2'b00;
  logic        brk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_break_matcher u_bus_break_matcher (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cyc_valid_i(valid), .cyc_dma_i(dma), .cyc_data_i(data),
    .cyc_write_i(wr), .cyc_size_i(sz), .brk_o(brk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pair_ok(input logic [1:0] s, input logic a);
    if (s == 2'b00) return 1'b1;
    return (s[0] && !a) || (s[1] && a);
  endfunction

  function automatic bit exp_brk(input logic [7:0] c, input logic d, input logic k,
                                 input logic w, input logic [1:0] z);
    bit m_ok, s_ok;
    if (c == 8'h00) return 1'b0;  // R7
    if (c[7:6] == 2'b00) m_ok = 1'b1;        // R3
    else if (c[6])       m_ok = !d;
    else                 m_ok = d;
    s_ok = (c[1:0] == 2'b00) || (int'(z) == int'(c[1:0]) - 1);  // R6
    return m_ok && pair_ok(c[5:4], k) && pair_ok(c[3:2], w) && s_ok;  // R4 R5
  endfunction

  task automatic wr_reg(input logic [15:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus(input logic d, input logic k, input logic w, input logic [1:0] z,
                     input bit exp, input string req);
    @(negedge clk);
    check(brk == 1'b0, "R8 pulse width", brk, 0);
    valid = 1'b1; dma = d; data = k; wr = w; sz = z;
    @(negedge clk);
    valid = 1'b0;
    check(brk == exp, req, brk, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdata == 16'h0 && brk == 1'b0, "R1 in reset", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata == 16'h0 && brk == 1'b0, "R1 after reset", rdata, 0);

    // R7: reset value never breaks, even with valid cycles
    bus(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R7 all off");

    // R2 / R10
    wr_reg(16'hFFFF);
    check(rdata == 16'h00FF, "R2 upper ignored", rdata, 16'h00FF);
    wr_reg(16'hA55A);
    check(rdata == 16'h005A, "R2/R10 readback", rdata, 16'h005A);

    // R8: no valid, matching attributes -> no break
    wr_reg(16'h0040);
    @(negedge clk);
    valid = 1'b0; dma = 1'b0;
    @(negedge clk);
    check(brk == 1'b0, "R8 no valid", brk, 0);

    // R9: write and bus cycle in one clock; old CPU-only setting applies
    @(negedge clk);
    we = 1'b1; wdata = 16'h0080;
    valid = 1'b1; dma = 1'b0; data = 1'b0; wr = 1'b0; sz = 2'b00;
    @(negedge clk);
    we = 1'b0; valid = 1'b0;
    check(brk == 1'b1, "R9 old value used", brk, 1);
    check(rdata == 16'h0080, "R9 new value stored", rdata, 16'h0080);
    bus(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R9 new value next cycle");
    bus(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, "R9/R3 DMA after write");

    // exhaustive sweep of implemented bits against every cycle
    for (int c = 0; c < 256; c++) begin
      wr_reg(16'(c));
      check(rdata == 16'(c), "R10 sweep readback", rdata, c);
      for (int a = 0; a < 32; a++) begin
        bus(a[4], a[3], a[2], a[1:0],
            exp_brk(8'(c), a[4], a[3], a[2], a[1:0]),
            "R3/R4/R5/R6/R7 sweep");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule